// File: doc/BRIEF.md
# SPI EEPROM Word Read Engine

This block sits behind a single 32-bit memory-mapped read register and fetches one 16-bit word from an attached serial EEPROM per request. Software writes the register with the start bit set and a word address in the address field. The engine then runs a complete SPI read on its own: it pulls chip select low, sends the read opcode 0x03 and the 16-bit byte address, and clocks in two data bytes. It packs the word into the upper half of the same register and raises a done flag, which software polls.

The engine shares the EEPROM pins with a direct software access path. While that path holds a grant, an accepted request waits and the pins are left alone. The serial clock is the system clock divided by a parameter, and the bus runs in SPI mode 0.

Top module: `eeprom_word_reader`

## Requirements
- R1: After reset the register reads 0x00000000, chip select is high and the serial clock is low.
- R2: A register write with bit 0 set while the engine is idle is accepted. It captures the word address from bits [2 +: ADDR_W] and clears the done flag at bit 1. From the next cycle until the word is captured, bit 0 reads 1.
- R3: Each transaction holds chip select low throughout. It sends 0x03 and then the 16-bit byte address (word address times 2), both MSB first, with the data out changed while the clock is low. It produces exactly 40 rising clock edges.
- R4: The engine samples serial data in on the rising clock edge. The first data byte received (even byte address) lands in bits 23:16 and the second (odd byte address) lands in bits 31:24, each received MSB first.
- R5: When the transaction ends, chip select returns high, bit 1 reads 1 and bit 0 reads 0. Done and data hold until the next accepted start.
- R6: A start written while a request is pending or a transaction is running is ignored. The address field and the word that is returned are those of the original request.
- R7: While the direct-access grant input is high, no transaction begins and chip select stays high. A pending request begins once the grant drops.
- R8: A register write with bit 0 clear changes nothing in the register and starts no transaction.
- R9: The serial clock idles low, and each clock phase lasts CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read value |
| direct_grant | input | 1 | High while direct software access owns the pins |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The bench reads every word address of the default configuration against a behavioural EEPROM. If the two bytes were swapped, the odd word half would come back in the even half. If the byte address were not doubled, the model would return the neighbouring word, and the bench also checks the opcode and address it decodes on each transaction. A second start written during a read is aimed at a different address; a design that accepted it would return the wrong word or show the wrong address field. The bench holds the grant high across a request and watches chip select, so an engine that ignored the grant would begin driving the pins early.

// File: rtl/eer_pkg.sv
package eer_pkg;
   localparam int unsigned OPC_BITS  = 8;
   localparam int unsigned ADR_BITS  = 16;
   localparam int unsigned DAT_BITS  = 16;
   localparam int unsigned CMD_BITS  = OPC_BITS + ADR_BITS;
   localparam int unsigned XFER_BITS = CMD_BITS + DAT_BITS;
   localparam logic [OPC_BITS-1:0] READ_OPC = 8'h03;
   localparam int unsigned FLD_START = 0;
   localparam int unsigned FLD_DONE  = 1;
   localparam int unsigned FLD_ADDR  = 2;
   localparam int unsigned FLD_DATA  = 16;
endpackage

// File: rtl/eer_tick_gen.sv
module eer_tick_gen #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad
         $error("DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick = en;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt <= '0;
            else if (!en)                   cnt <= '0;
            else if (cnt == CW'(DIV - 1))   cnt <= '0;
            else                            cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == CW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/eer_serdes.sv
module eer_serdes
   import eer_pkg::*;
#(
   parameter bit LOW_BYTE_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                launch,
   input  logic [ADR_BITS-1:0] byte_addr,
   input  logic                miso,
   output logic                cs_n,
   output logic                sck,
   output logic                mosi,
   output logic                busy,
   output logic                fin,
   output logic [DAT_BITS-1:0] word
);
   localparam int unsigned BW = $clog2(XFER_BITS + 1);

   logic [CMD_BITS-1:0] tx;
   logic [DAT_BITS-1:0] rx;
   logic [BW-1:0]       bcnt;
   logic                tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; cs_n <= 1'b1; sck <= 1'b0; mosi <= 1'b0;
         tx <= '0; rx <= '0; bcnt <= '0; tail <= 1'b0; fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (launch && !busy) begin
            busy <= 1'b1;
            cs_n <= 1'b0;
            sck  <= 1'b0;
            tx   <= {READ_OPC, byte_addr};
            mosi <= READ_OPC[OPC_BITS-1];
            bcnt <= '0;
            tail <= 1'b0;
         end else if (busy && tick) begin
            if (tail) begin
               busy <= 1'b0;
               cs_n <= 1'b1;
               fin  <= 1'b1;
            end else if (!sck) begin
               sck <= 1'b1;
               if (bcnt >= BW'(CMD_BITS)) rx <= {rx[DAT_BITS-2:0], miso};
            end else begin
               sck <= 1'b0;
               if (bcnt == BW'(XFER_BITS - 1)) begin
                  tail <= 1'b1;
                  mosi <= 1'b0;
               end else begin
                  bcnt <= bcnt + 1'b1;
                  tx   <= {tx[CMD_BITS-2:0], 1'b0};
                  mosi <= tx[CMD_BITS-2];
               end
            end
         end
      end
   end

   generate
      if (LOW_BYTE_FIRST) begin : g_swap
         assign word = {rx[7:0], rx[15:8]};
      end else begin : g_keep
         assign word = rx;
      end
   endgenerate

   // R9: clock idles low whenever chip select is released
   assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);
   // R3: chip select held low across the whole transaction
   assert_cs_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin && $past(busy)) |-> !cs_n);
   // R3: data out only changes while the clock is low
   assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sck) |=> (sck ? $stable(mosi) : 1'b1));
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
   import eer_pkg::*;
#(
   parameter int unsigned ADDR_W         = 6,
   parameter int unsigned CLK_DIV        = 2,
   parameter bit          LOW_BYTE_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        direct_grant,
   output logic        spi_cs_n,
   output logic        spi_sck,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   generate
      if (ADDR_W < 1 || ADDR_W > FLD_DATA - FLD_ADDR) begin : g_bad_aw
         $error("ADDR_W must fit between bit 2 and bit 15");
      end
   endgenerate

   logic [ADDR_W-1:0]   addr_q;
   logic [DAT_BITS-1:0] data_q;
   logic                done_q;
   logic                pending;
   logic                busy, fin, tick;
   logic [DAT_BITS-1:0] word;
   logic                accept, launch, active;
   logic [ADR_BITS-1:0] byte_addr;

   assign active    = pending || busy || fin;
   assign accept    = reg_wr_en && reg_wdata[FLD_START] && !active;
   assign launch    = pending && !direct_grant && !busy;
   assign byte_addr = ADR_BITS'({addr_q, 1'b0});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0; data_q <= '0; done_q <= 1'b0; pending <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= reg_wdata[FLD_ADDR +: ADDR_W];
            done_q  <= 1'b0;
            pending <= 1'b1;
         end else if (launch) begin
            pending <= 1'b0;
         end
         if (fin) begin
            done_q <= 1'b1;
            data_q <= word;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      reg_rdata[FLD_START]               = active;
      reg_rdata[FLD_DONE]                = done_q;
      reg_rdata[FLD_ADDR +: ADDR_W]      = addr_q;
      reg_rdata[FLD_DATA +: DAT_BITS]    = data_q;
   end

   eer_tick_gen #(.DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
   );

   eer_serdes #(.LOW_BYTE_FIRST(LOW_BYTE_FIRST)) u_serdes (
      .clk(clk), .rst_n(rst_n), .tick(tick), .launch(launch),
      .byte_addr(byte_addr), .miso(spi_miso), .cs_n(spi_cs_n),
      .sck(spi_sck), .mosi(spi_mosi), .busy(busy), .fin(fin), .word(word)
   );

   // R2: an accepted start clears done on the next cycle
   assert_done_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !done_q && active);
   // R5: completion raises done
   assert_done_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> done_q);
   // R5: done holds until the next accepted start
   assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !accept) |=> done_q);
   // R6: a start written while busy leaves the address untouched
   assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && active) |=> $stable(addr_q));
   // R7: an idle bus under grant is not taken
   assert_grant_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (direct_grant && spi_cs_n) |=> spi_cs_n);
endmodule

// File: tb/tb_eeprom_word_reader.sv
module tb_eeprom_word_reader;
   localparam int unsigned AW  = 6;
   localparam int unsigned DIV = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic direct_grant = 1'b0;
   logic spi_cs_n, spi_sck, spi_mosi;
   logic spi_miso = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   eeprom_word_reader #(.ADDR_W(AW), .CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .direct_grant(direct_grant), .spi_cs_n(spi_cs_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   function automatic logic [7:0] mem_byte(input int a);
      return 8'((a * 29 + 83) ^ (a >> 3));
   endfunction

   // behavioural EEPROM
   int bitn = 0;
   logic [23:0] cmd = '0;
   logic [23:0] last_cmd = '0;
   int last_edges = 0;
   int rise_cnt = 0;
   int hi_phase = 0;
   int min_phase = 1000;
   int max_phase = 0;

   always @(negedge spi_cs_n) begin bitn = 0; cmd = '0; rise_cnt = 0; end
   always @(posedge spi_cs_n) begin last_cmd = cmd; last_edges = rise_cnt; end
   always @(posedge spi_sck) if (!spi_cs_n) begin
      if (bitn < 24) cmd = {cmd[22:0], spi_mosi};
      bitn++; rise_cnt++;
   end
   always @(negedge spi_sck) if (!spi_cs_n && bitn >= 24 && bitn < 40) begin
      int k;
      logic [7:0] b;
      k = bitn - 24;
      b = mem_byte(int'(cmd[15:0]) + k / 8);
      spi_miso <= b[7 - k % 8];
   end
   // phase length monitor for the clock divider
   always @(posedge clk) begin
      cyc++;
      if (!spi_cs_n) begin
         if (spi_sck) begin
            hi_phase++;
         end else if (hi_phase > 0) begin
            if (hi_phase < min_phase) min_phase = hi_phase;
            if (hi_phase > max_phase) max_phase = hi_phase;
            hi_phase = 0;
         end
      end
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wdata = '0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!reg_rdata[1] && n < 2000) begin @(negedge clk); n++; end
   endtask

   function automatic logic [31:0] expect_reg(input int w);
      return {mem_byte(2 * w + 1), mem_byte(2 * w), 14'(w), 2'b10};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset register", reg_rdata, 32'h0);
      chk("R1 reset pins", {30'd0, spi_cs_n, spi_sck}, 32'h2);
      rst_n = 1'b1;
      @(negedge clk);

      // full sweep of word addresses
      for (int w = 0; w < (1 << AW); w++) begin
         wr(32'(w << 2) | 32'h1);
         if (w < 4) chk("R2 busy flag set, done cleared", {30'd0, reg_rdata[1:0]}, 32'h1);
         if (w < 4) chk("R2 address captured", 32'(reg_rdata[15:2]), 32'(w));
         wait_done();
         chk("R4 word data", expect_reg(w), reg_rdata);
         chk("R3 opcode and byte address", {8'd0, last_cmd}, {8'd0, 8'h03, 16'(2 * w)});
         if (w < 8) begin
            chk("R3 rising edge count", 32'(last_edges), 32'd40);
            chk("R5 cs released", {31'd0, spi_cs_n}, 32'h1);
         end
      end
      chk("R9 high phase min", 32'(min_phase), 32'(DIV));
      chk("R9 high phase max", 32'(max_phase), 32'(DIV));

      // done and data hold while idle
      repeat (50) @(negedge clk);
      chk("R5 result holds", reg_rdata, expect_reg((1 << AW) - 1));

      // write without start bit
      wr(32'(5 << 2));
      repeat (20) @(negedge clk);
      chk("R8 no-start write ignored", reg_rdata, expect_reg((1 << AW) - 1));
      chk("R8 no transaction", {31'd0, spi_cs_n}, 32'h1);

      // second start during a transaction
      wr(32'(9 << 2) | 32'h1);
      repeat (30) @(negedge clk);
      wr(32'(22 << 2) | 32'h1);
      chk("R6 address unchanged while busy", 32'(reg_rdata[15:2]), 32'd9);
      wait_done();
      chk("R6 first request served", reg_rdata, expect_reg(9));
      repeat (200) @(negedge clk);
      chk("R6 no second transaction", reg_rdata, expect_reg(9));

      // direct access grant blocks start
      direct_grant = 1'b1;
      wr(32'(17 << 2) | 32'h1);
      repeat (300) @(negedge clk);
      chk("R7 pins untouched under grant", {31'd0, spi_cs_n}, 32'h1);
      chk("R7 request pending", {30'd0, reg_rdata[1:0]}, 32'h1);
      direct_grant = 1'b0;
      wait_done();
      chk("R7 request served after release", reg_rdata, expect_reg(17));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule